// File: doc/BRIEF.md
# Capability Jump-and-Link Sentry Unit

This unit resolves capability jump-and-link operations for a capability-protected processor pipeline. In one cycle it takes the current program-counter capability (PCC), a target capability with an offset, and the current machine interrupt-enable bit. It then returns the next PCC, the link capability for the destination register, an optional write to the interrupt-enable bit, and an exception with a cause. Results appear one clock after the request.

Both operations are handled. The direct form (`is_jalr_i` = 0) adds an offset to the current program counter. The indirect form (`is_jalr_i` = 1) jumps through a target capability. The indirect form accepts sealed-entry (sentry) targets: it unseals them and may set or clear the interrupt-enable bit, depending on the sentry type. Every successful link is returned as a sentry whose type records the interrupt-enable state before the jump.

Bounds are not checked here. Fetch checks them later.

Top module: `jsu_top`

## Requirements
- R1: A result is registered on each rising edge where `req_i`=1, and `done_o` is high for exactly the following cycle. `done_o` is low in every other cycle. Reset clears `done_o`, `exc_o`, `cause_o`, `link_we_o` and `mie_we_o`.
- R2: The direct form (`is_jalr_i`=0) never raises an exception and never writes the interrupt-enable bit. Its next PCC is the current PCC, with the address set to (PC + offset) and bit 0 cleared.
- R3: When the indirect form succeeds, the next PCC carries the target's tag, execute permission and metadata. Its object type is 0 (unsealed), and its address is (target address + offset) with bit 0 cleared.
- R4: The indirect form checks the target in this order, and the first failure sets `exc_o` with `cause_o`:
  - untagged gives cause 1;
  - sealed with an object type outside 1..5 gives cause 2;
  - no execute permission gives cause 3.
  
  `cause_o` is 0 when there is no exception.
- R5: On an exception, the PCC outputs equal the current PCC inputs, `link_we_o`=0 and `mie_we_o`=0.
- R6: A successful indirect jump writes the interrupt-enable bit according to the target's object type:
  - type 0 (unsealed) or type 1 (inherit): no write;
  - type 2 (jump, disable) or type 4 (return, disable): write 0;
  - type 3 (jump, enable) or type 5 (return, enable): write 1.
- R7: On success, both forms assert `link_we_o`. The link has tag 1, and the PCC's execute permission and metadata. Its address is PC + 4 when `len4_i`=1, or PC + 2 otherwise. Its object type is 5 when `mie_i`=1, or 4 when `mie_i`=0.
- R8: Target and link address arithmetic wraps modulo 2^XLEN. No address range is checked at the jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| req_i | input | 1 | operation request |
| is_jalr_i | input | 1 | 1: indirect through target, 0: direct |
| len4_i | input | 1 | instruction is 4 bytes (else 2) |
| mie_i | input | 1 | current interrupt-enable bit |
| offset_i | input | XLEN | immediate offset |
| pcc_tag_i | input | 1 | PCC tag |
| pcc_perm_x_i | input | 1 | PCC execute permission |
| pcc_otype_i | input | OTYPE_W | PCC object type |
| pcc_addr_i | input | XLEN | PCC address (PC) |
| pcc_meta_i | input | META_W | PCC opaque bounds/permission metadata |
| tgt_tag_i | input | 1 | target tag |
| tgt_perm_x_i | input | 1 | target execute permission |
| tgt_otype_i | input | OTYPE_W | target object type |
| tgt_addr_i | input | XLEN | target address |
| tgt_meta_i | input | META_W | target metadata |
| done_o | output | 1 | result valid |
| exc_o | output | 1 | exception raised |
| cause_o | output | 2 | exception cause |
| pcc_tag_o | output | 1 | next PCC tag |
| pcc_perm_x_o | output | 1 | next PCC execute permission |
| pcc_otype_o | output | OTYPE_W | next PCC object type |
| pcc_addr_o | output | XLEN | next PCC address |
| pcc_meta_o | output | META_W | next PCC metadata |
| link_we_o | output | 1 | link write enable |
| link_tag_o | output | 1 | link tag |
| link_perm_x_o | output | 1 | link execute permission |
| link_otype_o | output | OTYPE_W | link sentry type |
| link_addr_o | output | XLEN | link address |
| link_meta_o | output | META_W | link metadata |
| mie_we_o | output | 1 | interrupt-enable write strobe |
| mie_o | output | 1 | interrupt-enable write value |

## Verification
A single indirect jump through a sentry can do three things in the same cycle:
- it unseals the target;
- it rewrites the interrupt-enable bit;
- it seals a link whose type depends on that same bit.

The bench provokes this by pairing each interrupt-changing sentry with the opposite `mie_i`. One example is a type-2 target with `mie_i`=1. In that case the link must carry type 5, from the old bit, while `mie_o` reports 0. Both results are sampled on the single `done_o` cycle.

// File: rtl/jsu_pkg.sv
package jsu_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_TAG  = 2'd1,
    CAUSE_SEAL = 2'd2,
    CAUSE_PERM = 2'd3
  } jsu_cause_e;

  typedef enum logic [1:0] {
    MIE_KEEP = 2'd0,
    MIE_CLR  = 2'd1,
    MIE_SET  = 2'd2
  } jsu_mie_act_e;

  localparam int unsigned OT_UNSEALED  = 0;
  localparam int unsigned OT_INHERIT   = 1;
  localparam int unsigned OT_JMP_DIS   = 2;
  localparam int unsigned OT_JMP_EN    = 3;
  localparam int unsigned OT_RET_DIS   = 4;
  localparam int unsigned OT_RET_EN    = 5;
endpackage

// File: rtl/jsu_target_check.sv
module jsu_target_check
  import jsu_pkg::*;
#(
  parameter int unsigned OTYPE_W = 4
) (
  input  logic               tag_i,
  input  logic               perm_x_i,
  input  logic [OTYPE_W-1:0] otype_i,
  output logic               exc_o,
  output jsu_cause_e         cause_o,
  output jsu_mie_act_e       mie_act_o
);
  logic sentry_ok;

  always_comb begin
    mie_act_o = MIE_KEEP;
    sentry_ok = 1'b1;
    unique case (otype_i)
      OTYPE_W'(OT_UNSEALED),
      OTYPE_W'(OT_INHERIT):  mie_act_o = MIE_KEEP;
      OTYPE_W'(OT_JMP_DIS),
      OTYPE_W'(OT_RET_DIS):  mie_act_o = MIE_CLR;
      OTYPE_W'(OT_JMP_EN),
      OTYPE_W'(OT_RET_EN):   mie_act_o = MIE_SET;
      default:               sentry_ok = 1'b0;
    endcase
  end

  // priority: tag, then seal type, then execute permission
  always_comb begin
    if (!tag_i)          cause_o = CAUSE_TAG;
    else if (!sentry_ok) cause_o = CAUSE_SEAL;
    else if (!perm_x_i)  cause_o = CAUSE_PERM;
    else                 cause_o = CAUSE_NONE;
  end

  assign exc_o = (cause_o != CAUSE_NONE);
endmodule

// File: rtl/jsu_addr_gen.sv
module jsu_addr_gen #(
  parameter int unsigned XLEN = 32
) (
  input  logic            is_jalr_i,
  input  logic            len4_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] tgt_addr_i,
  input  logic [XLEN-1:0] offset_i,
  output logic [XLEN-1:0] next_addr_o,
  output logic [XLEN-1:0] link_addr_o
);
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] sum;

  assign base        = is_jalr_i ? tgt_addr_i : pc_i;
  assign sum         = base + offset_i;
  assign next_addr_o = {sum[XLEN-1:1], 1'b0};
  assign link_addr_o = pc_i + (len4_i ? XLEN'(4) : XLEN'(2));
endmodule

// File: rtl/jsu_top.sv
module jsu_top
  import jsu_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned OTYPE_W = 4,
  parameter int unsigned META_W  = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               is_jalr_i,
  input  logic               len4_i,
  input  logic               mie_i,
  input  logic [XLEN-1:0]    offset_i,
  input  logic               pcc_tag_i,
  input  logic               pcc_perm_x_i,
  input  logic [OTYPE_W-1:0] pcc_otype_i,
  input  logic [XLEN-1:0]    pcc_addr_i,
  input  logic [META_W-1:0]  pcc_meta_i,
  input  logic               tgt_tag_i,
  input  logic               tgt_perm_x_i,
  input  logic [OTYPE_W-1:0] tgt_otype_i,
  input  logic [XLEN-1:0]    tgt_addr_i,
  input  logic [META_W-1:0]  tgt_meta_i,
  output logic               done_o,
  output logic               exc_o,
  output logic [1:0]         cause_o,
  output logic               pcc_tag_o,
  output logic               pcc_perm_x_o,
  output logic [OTYPE_W-1:0] pcc_otype_o,
  output logic [XLEN-1:0]    pcc_addr_o,
  output logic [META_W-1:0]  pcc_meta_o,
  output logic               link_we_o,
  output logic               link_tag_o,
  output logic               link_perm_x_o,
  output logic [OTYPE_W-1:0] link_otype_o,
  output logic [XLEN-1:0]    link_addr_o,
  output logic [META_W-1:0]  link_meta_o,
  output logic               mie_we_o,
  output logic               mie_o
);
  localparam logic [OTYPE_W-1:0] LINK_OT_EN  = OTYPE_W'(OT_RET_EN);
  localparam logic [OTYPE_W-1:0] LINK_OT_DIS = OTYPE_W'(OT_RET_DIS);

  logic         chk_exc;
  jsu_cause_e   chk_cause;
  jsu_mie_act_e chk_mie_act;
  logic [XLEN-1:0] next_addr, link_addr;

  jsu_target_check #(.OTYPE_W(OTYPE_W)) u_check (
    .tag_i     (tgt_tag_i),
    .perm_x_i  (tgt_perm_x_i),
    .otype_i   (tgt_otype_i),
    .exc_o     (chk_exc),
    .cause_o   (chk_cause),
    .mie_act_o (chk_mie_act)
  );

  jsu_addr_gen #(.XLEN(XLEN)) u_addr (
    .is_jalr_i   (is_jalr_i),
    .len4_i      (len4_i),
    .pc_i        (pcc_addr_i),
    .tgt_addr_i  (tgt_addr_i),
    .offset_i    (offset_i),
    .next_addr_o (next_addr),
    .link_addr_o (link_addr)
  );

  logic               exc_d;
  logic [1:0]         cause_d;
  logic               n_tag, n_x;
  logic [OTYPE_W-1:0] n_ot;
  logic [XLEN-1:0]    n_addr;
  logic [META_W-1:0]  n_meta;

  assign exc_d   = is_jalr_i & chk_exc;
  assign cause_d = is_jalr_i ? 2'(chk_cause) : 2'(CAUSE_NONE);

  always_comb begin
    n_tag  = pcc_tag_i;
    n_x    = pcc_perm_x_i;
    n_ot   = pcc_otype_i;
    n_addr = pcc_addr_i;
    n_meta = pcc_meta_i;
    if (!exc_d) begin
      n_addr = next_addr;
      if (is_jalr_i) begin
        n_tag  = tgt_tag_i;
        n_x    = tgt_perm_x_i;
        n_ot   = '0;
        n_meta = tgt_meta_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o        <= 1'b0;
      exc_o         <= 1'b0;
      cause_o       <= '0;
      pcc_tag_o     <= 1'b0;
      pcc_perm_x_o  <= 1'b0;
      pcc_otype_o   <= '0;
      pcc_addr_o    <= '0;
      pcc_meta_o    <= '0;
      link_we_o     <= 1'b0;
      link_tag_o    <= 1'b0;
      link_perm_x_o <= 1'b0;
      link_otype_o  <= '0;
      link_addr_o   <= '0;
      link_meta_o   <= '0;
      mie_we_o      <= 1'b0;
      mie_o         <= 1'b0;
    end else begin
      done_o <= req_i;
      if (req_i) begin
        exc_o         <= exc_d;
        cause_o       <= cause_d;
        pcc_tag_o     <= n_tag;
        pcc_perm_x_o  <= n_x;
        pcc_otype_o   <= n_ot;
        pcc_addr_o    <= n_addr;
        pcc_meta_o    <= n_meta;
        link_we_o     <= ~exc_d;
        link_tag_o    <= 1'b1;
        link_perm_x_o <= pcc_perm_x_i;
        // link type records interrupt state before any update
        link_otype_o  <= mie_i ? LINK_OT_EN : LINK_OT_DIS;
        link_addr_o   <= link_addr;
        link_meta_o   <= pcc_meta_i;
        mie_we_o      <= ~exc_d & is_jalr_i & (chk_mie_act != MIE_KEEP);
        mie_o         <= (chk_mie_act == MIE_SET);
      end
    end
  end

  a_r1_done_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> done_o);
  a_r1_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !done_o);
  a_r2_direct_no_exc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !is_jalr_i) |=> (!exc_o && !mie_we_o));
  a_r3_pcc_unsealed_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && is_jalr_i) |=> (exc_o || (pcc_otype_o == '0 && !pcc_addr_o[0])));
  a_r4_cause_matches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (exc_o == (cause_o != 2'd0)));
  a_r5_exc_holds_pcc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (!exc_o || (pcc_addr_o == $past(pcc_addr_i) && !link_we_o && !mie_we_o)));
  a_r7_link_sentry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (!link_we_o || (link_tag_o &&
      link_otype_o == ($past(mie_i) ? LINK_OT_EN : LINK_OT_DIS))));
endmodule

// File: tb/jsu_top_test.sv
`timescale 1ns/1ps
module jsu_top_test;
  localparam int XLEN = 32, OTW = 4, MW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic req, is_jalr, len4, mie;
  logic [XLEN-1:0] off;
  logic p_tag, p_x; logic [OTW-1:0] p_ot; logic [XLEN-1:0] p_addr; logic [MW-1:0] p_meta;
  logic t_tag, t_x; logic [OTW-1:0] t_ot; logic [XLEN-1:0] t_addr; logic [MW-1:0] t_meta;
  logic done, exc; logic [1:0] cause;
  logic o_tag, o_x; logic [OTW-1:0] o_ot; logic [XLEN-1:0] o_addr; logic [MW-1:0] o_meta;
  logic l_we, l_tag, l_x; logic [OTW-1:0] l_ot; logic [XLEN-1:0] l_addr; logic [MW-1:0] l_meta;
  logic m_we, m_val;

  jsu_top #(.XLEN(XLEN), .OTYPE_W(OTW), .META_W(MW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .is_jalr_i(is_jalr), .len4_i(len4),
    .mie_i(mie), .offset_i(off),
    .pcc_tag_i(p_tag), .pcc_perm_x_i(p_x), .pcc_otype_i(p_ot), .pcc_addr_i(p_addr),
    .pcc_meta_i(p_meta),
    .tgt_tag_i(t_tag), .tgt_perm_x_i(t_x), .tgt_otype_i(t_ot), .tgt_addr_i(t_addr),
    .tgt_meta_i(t_meta),
    .done_o(done), .exc_o(exc), .cause_o(cause),
    .pcc_tag_o(o_tag), .pcc_perm_x_o(o_x), .pcc_otype_o(o_ot), .pcc_addr_o(o_addr),
    .pcc_meta_o(o_meta),
    .link_we_o(l_we), .link_tag_o(l_tag), .link_perm_x_o(l_x), .link_otype_o(l_ot),
    .link_addr_o(l_addr), .link_meta_o(l_meta),
    .mie_we_o(m_we), .mie_o(m_val)
  );

  typedef struct packed {
    logic jalr, len4, tag, x;
    logic [3:0] ot;
    logic [31:0] taddr, off;
    logic mie, e_exc;
    logic [1:0] e_cause;
    logic e_mwe, e_mie;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b1,1'b0,1'b0,4'd0,32'h0,      32'h40,1'b1,1'b0,2'd0,1'b0,1'b0}, // R2
    '{1'b0,1'b0,1'b1,1'b1,4'd0,32'h0,      32'h7, 1'b0,1'b0,2'd0,1'b0,1'b0}, // R2 odd
    '{1'b1,1'b1,1'b1,1'b1,4'd0,32'h2000,   32'h4, 1'b1,1'b0,2'd0,1'b0,1'b0}, // R3
    '{1'b1,1'b1,1'b1,1'b1,4'd1,32'h3001,   32'h0, 1'b0,1'b0,2'd0,1'b0,1'b0}, // R6 inherit
    '{1'b1,1'b1,1'b1,1'b1,4'd2,32'h4000,   32'h2, 1'b1,1'b0,2'd0,1'b1,1'b0}, // R6 jmp dis
    '{1'b1,1'b0,1'b1,1'b1,4'd3,32'h5000,   32'h1, 1'b0,1'b0,2'd0,1'b1,1'b1}, // R6 jmp en
    '{1'b1,1'b1,1'b1,1'b1,4'd4,32'h6000,   32'h0, 1'b1,1'b0,2'd0,1'b1,1'b0}, // R6 ret dis
    '{1'b1,1'b1,1'b1,1'b1,4'd5,32'h7000,   32'h10,1'b0,1'b0,2'd0,1'b1,1'b1}, // R6 ret en
    '{1'b1,1'b1,1'b0,1'b1,4'd0,32'h8000,   32'h0, 1'b1,1'b1,2'd1,1'b0,1'b0}, // R4 tag
    '{1'b1,1'b1,1'b0,1'b1,4'd7,32'h8000,   32'h0, 1'b1,1'b1,2'd1,1'b0,1'b0}, // R4 tag first
    '{1'b1,1'b1,1'b1,1'b1,4'd6,32'h9000,   32'h0, 1'b0,1'b1,2'd2,1'b0,1'b0}, // R4 seal
    '{1'b1,1'b1,1'b1,1'b0,4'd9,32'h9000,   32'h0, 1'b0,1'b1,2'd2,1'b0,1'b0}, // R4 seal first
    '{1'b1,1'b1,1'b1,1'b0,4'd0,32'hA000,   32'h0, 1'b1,1'b1,2'd3,1'b0,1'b0}, // R4 perm
    '{1'b1,1'b0,1'b1,1'b0,4'd2,32'hB000,   32'h0, 1'b1,1'b1,2'd3,1'b0,1'b0}  // R4 perm sentry
  };

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req_tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req_tag, what, act, exp);
    end
  endtask

  task automatic issue();
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 20000) begin
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected<=20000", cyc);
        finish_run();
      end
    end
  end

  initial begin
    req = 0; is_jalr = 0; len4 = 0; mie = 0; off = '0;
    p_tag = 1; p_x = 1; p_ot = '0; p_addr = 32'h1000; p_meta = 16'hA5A5;
    t_tag = 0; t_x = 0; t_ot = '0; t_addr = '0; t_meta = 16'h3C3C;
    #12;
    chk(done == 0 && exc == 0 && l_we == 0 && m_we == 0 && cause == 0, "R1", "reset state",
        {done, exc, l_we, m_we, cause}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(done == 0, "R1", "idle done", done, 0);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] base, e_addr, e_link;
      vec_t v = VECS[i];
      is_jalr = v.jalr; len4 = v.len4; t_tag = v.tag; t_x = v.x; t_ot = v.ot;
      t_addr = v.taddr; off = v.off; mie = v.mie;
      base = v.jalr ? v.taddr : p_addr;
      e_addr = (base + v.off) & ~32'h1;
      e_link = p_addr + (v.len4 ? 32'd4 : 32'd2);
      issue();
      chk(done == 1, "R1", "done after req", done, 1);
      chk(exc == v.e_exc && cause == v.e_cause, "R4", $sformatf("vec %0d exc/cause", i),
          {exc, cause}, {v.e_exc, v.e_cause});
      chk(m_we == v.e_mwe && (!v.e_mwe || m_val == v.e_mie), "R6",
          $sformatf("vec %0d mie", i), {m_we, m_val}, {v.e_mwe, v.e_mie});
      if (v.e_exc) begin
        chk(o_addr == p_addr && o_meta == p_meta && o_tag == p_tag && o_ot == p_ot &&
            l_we == 0 && m_we == 0, "R5", $sformatf("vec %0d hold", i), o_addr, p_addr);
      end else begin
        if (v.jalr)
          chk(o_addr == e_addr && o_tag == v.tag && o_x == v.x && o_ot == 0 && o_meta == t_meta,
              "R3", $sformatf("vec %0d next pcc", i), {o_ot, o_addr}, {4'd0, e_addr});
        else
          chk(o_addr == e_addr && o_meta == p_meta && o_tag == p_tag,
              "R2", $sformatf("vec %0d next pcc", i), o_addr, e_addr);
        chk(l_we && l_tag && l_x == p_x && l_addr == e_link && l_meta == p_meta &&
            l_ot == (v.mie ? 4'd5 : 4'd4), "R7", $sformatf("vec %0d link", i),
            {l_ot, l_addr}, {(v.mie ? 4'd5 : 4'd4), e_link});
      end
      chk(done == 1, "R1", "done sampled", done, 1);
      @(negedge clk);
      chk(done == 0, "R1", "done single cycle", done, 0);
    end

    // R8 wrap on target and link
    is_jalr = 1; len4 = 1; mie = 0; t_tag = 1; t_x = 1; t_ot = 0;
    t_addr = 32'hFFFF_FFFF; off = 32'h3; p_addr = 32'hFFFF_FFFE;
    issue();
    chk(exc == 0 && o_addr == 32'h2, "R8", "target wrap", o_addr, 32'h2);
    chk(l_addr == 32'h2, "R8", "link wrap", l_addr, 32'h2);

    // R1 back-to-back requests: second result replaces first
    @(negedge clk); req = 1; is_jalr = 0; len4 = 0; off = 32'h10; p_addr = 32'h100;
    @(negedge clk); off = 32'h20;
    chk(done == 1 && o_addr == 32'h110, "R1", "b2b first", o_addr, 32'h110);
    @(negedge clk); req = 0;
    chk(done == 1 && o_addr == 32'h120, "R1", "b2b second", o_addr, 32'h120);
    @(negedge clk);
    chk(done == 0, "R1", "b2b drop", done, 0);

    finish_run();
  end
endmodule